// File: doc/BRIEF.md
# Timed Lock and Fuse Access Controller

This block sits beside a CPU core and handles the self-programming path for the device's protection and configuration bytes. Software writes an 8-bit control register with a specific arming pattern. That write opens a short window, counted in clock cycles, in which a store-program strobe can program the boot lock bits, or a load-program strobe can read back one of the fuse bytes or the lock byte. The window closes by itself. After it closes, a load-program strobe is left to the ordinary program-memory path, and the block does not answer it.

The lock and fuse bytes are held as registers, and their reset values are parameters. Programming only ever clears lock bits. A programmed bit reads as 0 and an unprogrammed bit reads as 1. While an EEPROM write is in progress, control-register writes are refused, so nothing can be armed during that time.

Top module: `nv_access_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, `rd_valid_o` is 0, and the lock byte equals its parameter defaults.
- R2: A control write arms the block only when data bits 6..0 equal 0b0001001. Bit 7 is don't-care. Any other value leaves the block unarmed, so a load-program strobe that follows gets no answer.
- R3: An armed load-program strobe is answered only in cycles 1 to 3 after the arming write (cycle 1 is the first cycle after the write). A strobe in cycle 4 or later gets no answer.
- R4: An armed store-program strobe is accepted only in cycles 1 to 4 after the arming write. A strobe in cycle 5 or later, or one with the block unarmed, changes nothing.
- R5: Control bits 3 and 0 clear by themselves. They clear in the cycle after an accepted operation. They also clear in cycle 5 after the arming write if no operation was accepted.
- R6: An answered read drives `rd_valid_o` high for the cycle after the strobe, with a value chosen by the pointer: 0x0000 gives the fuse low byte, 0x0001 the lock byte, 0x0002 the extended fuse byte, and 0x0003 the fuse high byte. Any other pointer gives 0xFF.
- R7: The lock byte has ones in bits 7..6, boot lock bits 5..2 (bit 5 down to bit 2 in stored order), and the two general lock bits in bits 1..0. The extended fuse byte reads with ones in bits 7..4.
- R8: For an accepted store-program strobe, each operand bit 5..2 that is 0 programs (clears) the matching boot lock bit, and each operand bit that is 1 leaves it as it is. Operand bits 7, 6, 1, 0 and the pointer have no effect, and no lock bit ever returns to 1.
- R9: While `ee_busy_i` is high, control writes are ignored and the control register keeps its value.
- R10: An arming write while the block is already armed restarts the window count from cycle 1.
- R11: While the block is unarmed, a load-program strobe never raises `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register contents |
| ee_busy_i | input | 1 | EEPROM write in progress; blocks control writes |
| spm_i | input | 1 | Store-program instruction strobe, single cycle |
| lpm_i | input | 1 | Load-program instruction strobe, single cycle |
| op_data_i | input | 8 | Data operand for store-program |
| op_addr_i | input | 16 | Pointer operand |
| rd_data_o | output | 8 | Read value for an answered load-program |
| rd_valid_o | output | 1 | High one cycle after an answered load-program |
| lock_byte_o | output | 8 | Current lock byte |

## Verification
Some properties are checked by assertions on every cycle: the window counter stays inside its bound, the control bits are clear whenever the arming drops without a new write, the control register holds while EEPROM is busy, lock bits never rise, and a read answer always follows a load-program strobe with the unused extended-fuse bits set. Other behaviour shows only in the bench scenarios: the exact edges of the three-cycle and four-cycle windows, the restart caused by re-arming, which arming patterns are accepted, and the way operand bits map onto lock bits.

// File: rtl/nv_access_pkg.sv
package nv_access_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BLB_N  = 4;
  localparam int unsigned LB_N   = 2;
  localparam int unsigned EXT_N  = 4;
  localparam int unsigned BIT_SEL = 3;
  localparam int unsigned BIT_EN  = 0;
  localparam logic [6:0] ARM_PAT = 7'b0001001;

  typedef enum logic [2:0] {
    SEL_FUSE_LO = 3'd0,
    SEL_LOCK    = 3'd1,
    SEL_FUSE_EX = 3'd2,
    SEL_FUSE_HI = 3'd3,
    SEL_NONE    = 3'd4
  } rd_sel_e;
endpackage

// File: rtl/nv_arm_window.sv
module nv_arm_window
  import nv_access_pkg::*;
#(
  parameter int unsigned WIN_SPM = 4,
  parameter int unsigned WIN_LPM = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              spm_i,
  input  logic              lpm_i,
  output logic [BYTE_W-1:0] ctl_o,
  output logic              spm_ok_o,
  output logic              lpm_ok_o
);
  localparam int unsigned CNT_W = $clog2(WIN_SPM + 1);
  localparam logic [CNT_W-1:0] CNT_LPM = CNT_W'(WIN_LPM);
  localparam logic [CNT_W-1:0] CNT_SPM = CNT_W'(WIN_SPM);

  logic [BYTE_W-1:0] ctl_q;
  logic              arm_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_ok, arm_pat, done;

  assign wr_ok    = we_i & ~busy_i;
  assign arm_pat  = (wdata_i[6:0] == ARM_PAT);
  assign spm_ok_o = arm_q & spm_i;
  assign lpm_ok_o = arm_q & lpm_i & (cnt_q <= CNT_LPM);
  assign done     = spm_ok_o | lpm_ok_o | (cnt_q == CNT_SPM);
  assign ctl_o    = ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else if (wr_ok) begin
      ctl_q <= wdata_i;
      arm_q <= arm_pat;
      cnt_q <= arm_pat ? CNT_W'(1) : '0;
    end else if (arm_q && done) begin
      arm_q          <= 1'b0;
      cnt_q          <= '0;
      ctl_q[BIT_SEL] <= 1'b0;
      ctl_q[BIT_EN]  <= 1'b0;
    end else if (arm_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_SPM)); // R4
  AST_DISARM_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(arm_q) && !$past(wr_ok)) |-> (!ctl_q[BIT_SEL] && !ctl_q[BIT_EN])); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !arm_q) |=> $stable(ctl_q)); // R9
endmodule

// File: rtl/nv_lock_store.sv
module nv_lock_store
  import nv_access_pkg::*;
#(
  parameter logic [BLB_N-1:0] BLB_RST = 4'hF,
  parameter logic [LB_N-1:0]  LB_RST  = 2'b11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spm_ok_i,
  input  logic [BLB_N-1:0]  blb_data_i,
  output logic [BYTE_W-1:0] lock_byte_o
);
  logic [BLB_N-1:0] blb_q;
  logic [LB_N-1:0]  lb_q;

  for (genvar g = 0; g < BLB_N; g++) begin : g_blb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        blb_q[g] <= BLB_RST[g];
      else if (spm_ok_i && !blb_data_i[g]) blb_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lb_q <= LB_RST;
    else         lb_q <= lb_q;
  end

  assign lock_byte_o = {2'b11, blb_q, lb_q};

  AST_LOCK_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((blb_q & ~$past(blb_q)) == '0)); // R8
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spm_ok_i |=> $stable(blb_q)); // R8
endmodule

// File: rtl/nv_read_mux.sv
module nv_read_mux
  import nv_access_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 16,
  parameter logic [BYTE_W-1:0] FUSE_LO_RST = 8'h62,
  parameter logic [BYTE_W-1:0] FUSE_HI_RST = 8'hD9,
  parameter logic [EXT_N-1:0]  FUSE_EX_RST = 4'hD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lpm_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] lock_byte_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [BYTE_W-1:0] fuse_lo_q, fuse_hi_q;
  logic [EXT_N-1:0]  fuse_ex_q;
  logic [BYTE_W-1:0] rd_q, rd_d;
  logic              vld_q;
  rd_sel_e           sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fuse_lo_q <= FUSE_LO_RST;
      fuse_hi_q <= FUSE_HI_RST;
      fuse_ex_q <= FUSE_EX_RST;
    end else begin
      fuse_lo_q <= fuse_lo_q;
      fuse_hi_q <= fuse_hi_q;
      fuse_ex_q <= fuse_ex_q;
    end
  end

  always_comb begin
    if (addr_i[ADDR_W-1:2] != '0) sel = SEL_NONE;
    else                          sel = rd_sel_e'({1'b0, addr_i[1:0]});
  end

  always_comb begin
    unique case (sel)
      SEL_FUSE_LO: rd_d = fuse_lo_q;
      SEL_LOCK:    rd_d = lock_byte_i;
      SEL_FUSE_EX: rd_d = {{(BYTE_W-EXT_N){1'b1}}, fuse_ex_q};
      SEL_FUSE_HI: rd_d = fuse_hi_q;
      default:     rd_d = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= lpm_ok_i;
      if (lpm_ok_i) rd_q <= rd_d;
    end
  end

  assign rd_data_o  = rd_q;
  assign rd_valid_o = vld_q;
endmodule

// File: rtl/nv_access_ctrl.sv
module nv_access_ctrl
  import nv_access_pkg::*;
#(
  parameter int unsigned WIN_SPM     = 4,
  parameter int unsigned WIN_LPM     = 3,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [7:0]  FUSE_LO_RST = 8'h62,
  parameter logic [7:0]  FUSE_HI_RST = 8'hD9,
  parameter logic [3:0]  FUSE_EX_RST = 4'hD,
  parameter logic [3:0]  BLB_RST     = 4'hF,
  parameter logic [1:0]  LB_RST      = 2'b10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  output logic [7:0]        ctl_rdata_o,
  input  logic              ee_busy_i,
  input  logic              spm_i,
  input  logic              lpm_i,
  input  logic [7:0]        op_data_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic [7:0]        lock_byte_o
);
  logic spm_ok, lpm_ok;

  nv_arm_window #(
    .WIN_SPM(WIN_SPM),
    .WIN_LPM(WIN_LPM)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .busy_i  (ee_busy_i),
    .spm_i   (spm_i),
    .lpm_i   (lpm_i),
    .ctl_o   (ctl_rdata_o),
    .spm_ok_o(spm_ok),
    .lpm_ok_o(lpm_ok)
  );

  nv_lock_store #(
    .BLB_RST(BLB_RST),
    .LB_RST (LB_RST)
  ) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .spm_ok_i   (spm_ok),
    .blb_data_i (op_data_i[5:2]),
    .lock_byte_o(lock_byte_o)
  );

  nv_read_mux #(
    .ADDR_W     (ADDR_W),
    .FUSE_LO_RST(FUSE_LO_RST),
    .FUSE_HI_RST(FUSE_HI_RST),
    .FUSE_EX_RST(FUSE_EX_RST)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lpm_ok_i   (lpm_ok),
    .addr_i     (op_addr_i),
    .lock_byte_i(lock_byte_o),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  AST_VALID_AFTER_LPM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(lpm_i)); // R3
  AST_EXT_TOP_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(op_addr_i) == ADDR_W'(2)) |-> (rd_data_o[7:4] == 4'hF)); // R7
  AST_LOCK_TOP_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_byte_o[7:6] == 2'b11); // R7
endmodule

// File: tb/nv_access_ctrl_test.sv
module nv_access_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        ee_busy = 1'b0;
  logic        spm = 1'b0;
  logic        lpm = 1'b0;
  logic [7:0]  op_data = '0;
  logic [15:0] op_addr = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [7:0]  lock_byte;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  nv_access_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .ctl_rdata_o(ctl_rdata), .ee_busy_i(ee_busy), .spm_i(spm), .lpm_i(lpm),
    .op_data_i(op_data), .op_addr_i(op_addr), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .lock_byte_o(lock_byte)
  );

  // {wdata, op cycle, pointer, expect valid, expect data}
  localparam logic [35:0] VEC [10] = '{
    {8'h09, 3'd1, 16'h0000, 1'b1, 8'h62},  // R6 fuse low
    {8'h89, 3'd2, 16'h0001, 1'b1, 8'hFE},  // R2 bit7 don't care, R7 lock
    {8'h09, 3'd3, 16'h0002, 1'b1, 8'hFD},  // R7 extended
    {8'h09, 3'd3, 16'h0003, 1'b1, 8'hD9},  // R3 last cycle, fuse high
    {8'h09, 3'd4, 16'h0000, 1'b0, 8'h00},  // R3 too late
    {8'h09, 3'd1, 16'h0100, 1'b1, 8'hFF},  // R6 out-of-range pointer
    {8'h19, 3'd1, 16'h0001, 1'b0, 8'h00},  // R2 bad pattern
    {8'h0B, 3'd1, 16'h0001, 1'b0, 8'h00},  // R2 bad pattern
    {8'h01, 3'd2, 16'h0000, 1'b0, 8'h00},  // R11 unarmed read
    {8'h09, 3'd5, 16'h0001, 1'b0, 8'h00}   // R3 expired
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [7:0] w);
    ctl_we = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic do_lpm(input logic [15:0] a);
    lpm = 1'b1; op_addr = a;
    @(negedge clk);
    lpm = 1'b0;
  endtask

  task automatic do_spm(input logic [7:0] d, input logic [15:0] a);
    spm = 1'b1; op_data = d; op_addr = a;
    @(negedge clk);
    spm = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R1 ctl", 16'(ctl_rdata), 16'h00);
    chk("R1 valid", 16'(rd_valid), 16'h0);
    chk("R1 lock", 16'(lock_byte), 16'hFE);

    for (int i = 0; i < 10; i++) begin
      arm(VEC[i][35:28]);
      cyc(int'(VEC[i][27:25]) - 1);
      do_lpm(VEC[i][24:9]);
      chk("R2/R3/R6/R11 valid", 16'(rd_valid), 16'(VEC[i][8]));
      if (VEC[i][8]) chk("R6/R7 data", 16'(rd_data), 16'(VEC[i][7:0]));
      arm(8'h00);
      cyc(1);
    end

    // R5 expiry
    arm(8'h09);
    chk("R5 armed c1", 16'(ctl_rdata), 16'h09);
    cyc(3);
    chk("R5 armed c4", 16'(ctl_rdata), 16'h09);
    cyc(1);
    chk("R5 cleared c5", 16'(ctl_rdata), 16'h00);

    // R5 completion
    arm(8'h09);
    do_lpm(16'h0001);
    chk("R5 clear after read", 16'(ctl_rdata), 16'h00);

    // R10 restart
    arm(8'h09);
    cyc(2);
    arm(8'h09);
    cyc(2);
    do_lpm(16'h0000);
    chk("R10 valid", 16'(rd_valid), 16'h1);
    chk("R10 data", 16'(rd_data), 16'h62);
    cyc(3);

    // R9 busy
    ee_busy = 1'b1;
    arm(8'h09);
    chk("R9 ctl", 16'(ctl_rdata), 16'h00);
    do_lpm(16'h0001);
    chk("R9 no read", 16'(rd_valid), 16'h0);
    ee_busy = 1'b0;
    cyc(1);

    // R4/R8 spm at last cycle
    arm(8'h09);
    cyc(3);
    do_spm(8'hDB, 16'h1234);
    chk("R8 program", 16'(lock_byte), 16'hDA);
    chk("R5 clear after spm", 16'(ctl_rdata), 16'h00);

    // R4 late spm
    arm(8'h09);
    cyc(4);
    do_spm(8'h00, 16'h0001);
    chk("R4 late spm", 16'(lock_byte), 16'hDA);

    // R4 unarmed spm
    do_spm(8'h00, 16'h0001);
    chk("R4 unarmed spm", 16'(lock_byte), 16'hDA);

    // R8 ones and outer bits have no effect
    arm(8'h09);
    do_spm(8'h3C, 16'h0000);
    chk("R8 no effect", 16'(lock_byte), 16'hDA);

    // R8 clear all, R7 readback
    arm(8'h09);
    do_spm(8'h00, 16'h0001);
    chk("R8 all clear", 16'(lock_byte), 16'hC2);
    arm(8'h09);
    do_lpm(16'h0001);
    chk("R7 lock read", 16'(rd_data), 16'hC2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule